// File: doc/BRIEF.md
# Bus Transceiver with Address Match

This block is a 4-bit bidirectional buffer between a system data bus and a peripheral data port. The bus side uses active-low levels with open-drain drive, so a low line carries logic 1. The peripheral side uses active-high levels with tri-state drive. Data crossing the block therefore changes electrical polarity. Two request inputs select receive (bus to peripheral), transmit (peripheral to bus) or disabled. Every mode change goes through a programmable blanking interval, during which neither side drives, so the two sides are never driven at the same moment.

Two side functions share the bus pins. An address comparator checks the upper three bus lines against three jumper settings, and any jumper can be set to don't-care. The comparator pulls an open-drain match line low on a mismatch, so the match outputs of several transceivers can be wired together as an AND. A vector generator pulls the upper three bus lines according to three constant jumpers, whatever the mode. Each open-drain pin is modelled as a pull-low request, with 1 meaning the pin is pulled low. Each tri-state pin is modelled as a value and an enable.

Top module: `bus_xcvr`

## Requirements
- R1: While rst_ni is low, per_oe_o is 0 and per_out_o is 0, and bus_pull_o holds no bits other than those requested by vec_jmp_i.
- R2: In receive mode, per_oe_o is 1 and per_out_o equals ~bus_in_i, which is the logic value of the active-low bus.
- R3: In transmit mode, per_oe_o is 0 and each bus_pull_o bit is 1 wherever per_in_i holds a 1.
- R4: The requests decode as follows: rx_req_i alone selects receive, tx_req_i alone selects transmit, neither selects disabled, and both together select disabled.
- R5: In disabled mode, per_oe_o is 0, per_out_o is 0 and there is no data pull on the bus.
- R6: A new mode request is captured at a clock edge. From that edge, both sides stay undriven for DEAD_CYC edges, and the new mode takes effect at the DEAD_CYC-th edge after capture.
- R7: A further change of request during the blanking interval restarts the interval, and the abandoned mode is never enabled.
- R8: Jumper k sits in addr_jmp_i[2k+1:2k] and is compared with bus logic bit k+1. Code 2'b00 expects 0 and 2'b01 expects 1. With match_en_ni low, match_pull_o is 1 exactly when some compared bit differs.
- R9: Jumper codes 2'b10 and 2'b11 mark the bit don't-care, so it never causes a mismatch.
- R10: With match_en_ni high, match_pull_o is 0 whatever the bus and jumper values.
- R11: vec_jmp_i[k]=1 sets bus_pull_o[k+1] in every mode and during blanking. bus_pull_o[0] is never set by the vector.
- R12: When a vector bit is 1 and transmit sends a 0 on the same line, the line is still pulled, because the bus pull is the OR of both requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_req_i | input | 1 | Receive request |
| tx_req_i | input | 1 | Transmit request |
| bus_in_i | input | 4 | Bus pin levels (low = logic 1) |
| bus_pull_o | output | 4 | Bus pull-low requests (1 = pull low) |
| per_in_i | input | 4 | Peripheral pin levels (high = logic 1) |
| per_out_o | output | 4 | Peripheral drive value |
| per_oe_o | output | 1 | Peripheral tri-state enable |
| addr_jmp_i | input | 6 | Address jumpers, 2 bits each |
| match_en_ni | input | 1 | Match output enable, active low |
| match_pull_o | output | 1 | Match pull-low request (1 = mismatch) |
| vec_jmp_i | input | 3 | Vector jumpers for bus lines 3..1 |

## Verification
The only state in the block is the mode sequencer. A wrong target, counter or applied mode shows at the ports within one clock edge as an early, late or missing change in per_oe_o, or in the data bits of bus_pull_o. The bench counts edges exactly from the edge that captures a request. It checks that drivers stay off until the DEAD_CYC-th edge and then come on, including when a request restarts the interval. The match and vector paths are combinational, so any fault in them appears in the same cycle as the stimulus.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_RX  = 2'd1,
    MODE_TX  = 2'd2
  } mode_e;
endpackage

// File: rtl/xcvr_mode_ctl.sv
module xcvr_mode_ctl
  import xcvr_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_req_i,
  input  logic tx_req_i,
  output logic rx_en_o,
  output logic tx_en_o
);
  localparam int unsigned CNT_W = $clog2(DEAD_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DEAD_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  mode_e            req_mode, tgt_q, cur_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    unique case ({tx_req_i, rx_req_i})
      2'b01:   req_mode = MODE_RX;
      2'b10:   req_mode = MODE_TX;
      default: req_mode = MODE_OFF; // both or neither
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q <= MODE_OFF;
      cur_q <= MODE_OFF;
      cnt_q <= '0;
    end else if (req_mode != tgt_q) begin
      // new request: drop drivers, restart blanking
      tgt_q <= req_mode;
      cur_q <= MODE_OFF;
      cnt_q <= CNT_LOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_LAST) cur_q <= tgt_q;
    end
  end

  assign rx_en_o = (cur_q == MODE_RX);
  assign tx_en_o = (cur_q == MODE_TX);

  AST_CHANGE_BLANKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_mode != tgt_q) |=> (!rx_en_o && !tx_en_o)); // R6
  AST_BOTH_REQ_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_req_i && tx_req_i) |=> (!rx_en_o && !tx_en_o)); // R4
  AST_RX_AFTER_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_en_o) |-> $past(!tx_en_o)); // R6
  AST_TX_AFTER_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_o) |-> $past(!rx_en_o)); // R6
  AST_EN_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rx_en_o, tx_en_o})); // R5
endmodule

// File: rtl/xcvr_addr_cmp.sv
module xcvr_addr_cmp #(
  parameter int unsigned JMP_N = 3
) (
  input  logic [JMP_N-1:0]   bus_bit_i,
  input  logic [2*JMP_N-1:0] jmp_i,
  input  logic               match_en_ni,
  output logic               match_pull_o
);
  logic [JMP_N-1:0] miss;

  for (genvar k = 0; k < JMP_N; k++) begin : g_bit
    // upper code bit set: don't-care
    assign miss[k] = !jmp_i[2*k+1] && (jmp_i[2*k] != bus_bit_i[k]);
  end

  assign match_pull_o = !match_en_ni && (|miss);
endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned JMP_N = 3
) (
  input  logic             rx_en_i,
  input  logic             tx_en_i,
  input  logic [WIDTH-1:0] bus_in_i,
  input  logic [WIDTH-1:0] per_in_i,
  input  logic [JMP_N-1:0] vec_i,
  output logic [WIDTH-1:0] bus_pull_o,
  output logic [WIDTH-1:0] per_out_o,
  output logic             per_oe_o
);
  localparam int unsigned LOW_N = WIDTH - JMP_N;

  logic [WIDTH-1:0] data_pull, vec_pull;

  assign per_out_o = rx_en_i ? ~bus_in_i : '0;
  assign per_oe_o  = rx_en_i;
  assign data_pull = tx_en_i ? per_in_i : '0;
  assign vec_pull  = {vec_i, {LOW_N{1'b0}}};
  assign bus_pull_o = data_pull | vec_pull; // wired-OR of pull-downs
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH    = 4,
  parameter int unsigned JMP_N    = 3,
  parameter int unsigned DEAD_CYC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rx_req_i,
  input  logic               tx_req_i,
  input  logic [WIDTH-1:0]   bus_in_i,
  output logic [WIDTH-1:0]   bus_pull_o,
  input  logic [WIDTH-1:0]   per_in_i,
  output logic [WIDTH-1:0]   per_out_o,
  output logic               per_oe_o,
  input  logic [2*JMP_N-1:0] addr_jmp_i,
  input  logic               match_en_ni,
  output logic               match_pull_o,
  input  logic [JMP_N-1:0]   vec_jmp_i
);
  localparam int unsigned LOW_N = WIDTH - JMP_N;

  logic rx_en, tx_en;

  xcvr_mode_ctl #(.DEAD_CYC(DEAD_CYC)) u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rx_req_i (rx_req_i),
    .tx_req_i (tx_req_i),
    .rx_en_o  (rx_en),
    .tx_en_o  (tx_en)
  );

  xcvr_datapath #(.WIDTH(WIDTH), .JMP_N(JMP_N)) u_dp (
    .rx_en_i    (rx_en),
    .tx_en_i    (tx_en),
    .bus_in_i   (bus_in_i),
    .per_in_i   (per_in_i),
    .vec_i      (vec_jmp_i),
    .bus_pull_o (bus_pull_o),
    .per_out_o  (per_out_o),
    .per_oe_o   (per_oe_o)
  );

  xcvr_addr_cmp #(.JMP_N(JMP_N)) u_cmp (
    .bus_bit_i    (~bus_in_i[WIDTH-1:LOW_N]),
    .jmp_i        (addr_jmp_i),
    .match_en_ni  (match_en_ni),
    .match_pull_o (match_pull_o)
  );

  AST_VEC_ALWAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_jmp_i & ~bus_pull_o[WIDTH-1:LOW_N]) == '0); // R11
  AST_MATCH_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_en_ni |-> !match_pull_o); // R10
  AST_PER_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !per_oe_o |-> (per_out_o == '0)); // R5
  AST_NO_LOW_PULL_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_oe_o |-> (bus_pull_o[LOW_N-1:0] == '0)); // R2
endmodule

// File: tb/tb_bus_xcvr.sv
module tb_bus_xcvr;
  localparam int unsigned D = 4;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       rx_req_i = 1'b0, tx_req_i = 1'b0;
  logic [3:0] bus_in_i = 4'hF, per_in_i = 4'h0;
  logic [5:0] addr_jmp_i = 6'h3F;
  logic       match_en_ni = 1'b1;
  logic [2:0] vec_jmp_i = 3'b000;
  logic [3:0] bus_pull_o, per_out_o;
  logic       per_oe_o, match_pull_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  bus_xcvr #(.DEAD_CYC(D)) dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_pull(int m, logic [3:0] per, logic [2:0] vec);
    return ((m == 2) ? per : 4'h0) | {vec, 1'b0};
  endfunction

  function automatic logic exp_match(logic [3:0] bus, logic [5:0] j, logic en_n);
    logic [2:0] lv = ~bus[3:1];
    logic miss = 1'b0;
    for (int k = 0; k < 3; k++)
      if (!j[2*k+1] && (j[2*k] != lv[k])) miss = 1'b1;
    return !en_n && miss;
  endfunction

  // m: 0 off, 1 rx, 2 tx
  task automatic check_ports(input int m, input string tag);
    chk(per_oe_o == (m == 1), {tag, " oe"}, {7'd0, per_oe_o}, {7'd0, m == 1});
    chk(per_out_o == ((m == 1) ? ~bus_in_i : 4'h0), {tag, " per_out"}, {4'd0, per_out_o},
        {4'd0, (m == 1) ? ~bus_in_i : 4'h0});
    chk(bus_pull_o == exp_pull(m, per_in_i, vec_jmp_i), {tag, " bus_pull"}, {4'd0, bus_pull_o},
        {4'd0, exp_pull(m, per_in_i, vec_jmp_i)});
    chk(match_pull_o == exp_match(bus_in_i, addr_jmp_i, match_en_ni), {tag, " match"},
        {7'd0, match_pull_o}, {7'd0, exp_match(bus_in_i, addr_jmp_i, match_en_ni)});
  endtask

  // drive request, then count edges from capture edge
  task automatic go_mode(input bit rx, input bit tx, input int m, input string tag);
    @(negedge clk_i);
    rx_req_i = rx; tx_req_i = tx;
    per_in_i = 4'hF; vec_jmp_i = 3'b000;
    for (int c = 0; c <= D; c++) begin
      @(posedge clk_i); #2;
      check_ports((c == D) ? m : 0, tag);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int unsigned s;
    s = $urandom(32'h5EED);
    vec_jmp_i = 3'b101;
    #5;
    chk(per_oe_o == 1'b0, "R1 reset oe", {7'd0, per_oe_o}, 8'd0);
    chk(bus_pull_o == 4'b1010, "R1 reset pull", {4'd0, bus_pull_o}, 8'h0A);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;

    go_mode(1, 0, 1, "R6 R4 rx");
    go_mode(0, 1, 2, "R6 R4 tx");
    go_mode(1, 1, 0, "R4 both off");
    go_mode(1, 0, 1, "R6 rx again");
    go_mode(0, 0, 0, "R4 R5 none off");

    // R7: restart mid-interval; rx must never appear
    @(negedge clk_i); rx_req_i = 1; tx_req_i = 0; per_in_i = 4'hF;
    repeat (2) begin @(posedge clk_i); #2; check_ports(0, "R7 pending rx"); end
    go_mode(0, 1, 2, "R7 restart tx");

    // R12: transmit 0 under vector 1
    @(negedge clk_i); per_in_i = 4'h0; vec_jmp_i = 3'b111; #1;
    chk(bus_pull_o == 4'b1110, "R12 or pull", {4'd0, bus_pull_o}, 8'h0E);

    // R9: all don't-care, R10: gated
    @(negedge clk_i); addr_jmp_i = 6'b101110; match_en_ni = 0; bus_in_i = 4'h0; #1;
    chk(match_pull_o == 1'b0, "R9 dc match", {7'd0, match_pull_o}, 8'd0);
    addr_jmp_i = 6'b000000; #1;
    chk(match_pull_o == 1'b1, "R8 mismatch", {7'd0, match_pull_o}, 8'd1);
    match_en_ni = 1; #1;
    chk(match_pull_o == 1'b0, "R10 gated", {7'd0, match_pull_o}, 8'd0);

    // random sweep per mode: R2 R3 R5 R8 R9 R10 R11 R12
    for (int m = 0; m < 3; m++) begin
      if (m == 0) go_mode(0, 0, 0, "R5 enter off");
      if (m == 1) go_mode(1, 0, 1, "R2 enter rx");
      if (m == 2) go_mode(0, 1, 2, "R3 enter tx");
      for (int i = 0; i < 60; i++) begin
        @(negedge clk_i);
        bus_in_i = 4'($urandom); per_in_i = 4'($urandom);
        addr_jmp_i = 6'($urandom); match_en_ni = 1'($urandom);
        vec_jmp_i = 3'($urandom);
        #1;
        check_ports(m, (m == 1) ? "R2 R8 R11 rand" : (m == 2) ? "R3 R12 R9 rand" : "R5 R10 rand");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule